// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion in units of a slow ADC clock. That clock is derived from either the bus clock or an oscillator input, through a prescaler with five divide ratios. A write to the control register starts a conversion. A write while a conversion is running cancels it and starts again. The block sends a sample strobe and then one step strobe per result bit to the analog SAR model. It captures the code the model returns and raises a one-bus-clock done pulse.

The ADC clock runs freely and is not aligned to the write that starts a conversion. The first ADC cycle of a single conversion is therefore a partial one, lasting from one bus cycle up to a whole ADC cycle, and it is counted as the seventeenth. In continuous mode, each done restarts the sequence on the same ADC edge, so later conversions are exactly sixteen ADC cycles apart. All logic runs on the bus clock. The oscillator is sampled through a two-flop synchronizer, and its rising edges become source ticks.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, conv_done, sar_sample and sar_step are low and conv_result is zero.
- R2: A pulse on ctl_wr with ctl_chan not all ones starts a conversion. conv_done rises on the 17th ADC tick after the write: the first tick ends the partial cycle, and 16 full ADC cycles follow.
- R3: cfg_src_osc=0 selects the bus clock as the prescaler source. cfg_src_osc=1 selects rising edges of osc_clk, seen through a two-flop synchronizer.
- R4: cfg_div codes 0,1,2,3,4 divide the source by 1,2,4,8,16. Codes 5,6,7 divide by 1.
- R5: conv_done is high for exactly one bus clock. At the same time conv_result shows the sar_code value present on the last ADC tick.
- R6: sar_sample pulses on the first ADC tick of a conversion. Exactly RES_BITS sar_step pulses follow before conv_done, and sar_sample and sar_step are never high together.
- R7: With ctl_cont=1 in the starting write, each done restarts the conversion. The next done comes 16 ADC cycles later, and this repeats until another control write.
- R8: A control write during a conversion discards it: no done appears for it, and counting restarts from the new write.
- R9: A control write with ctl_chan all ones powers the converter down. No conversion starts, any running one is cancelled, and no sample, step or done follows.
- R10: A pulse on cfg_wr loads the source and divide fields and resets the prescaler phase. With the bus source, ADC ticks then fall on the edges N, 2N, 3N... bus cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Alternate oscillator clock, sampled as data |
| cfg_wr | input | 1 | Clock register write strobe |
| cfg_src_osc | input | 1 | Source select: 0 bus clock, 1 oscillator |
| cfg_div | input | 3 | Prescaler divide code |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_chan | input | CHAN_W | Channel field; all ones powers down |
| ctl_cont | input | 1 | Continuous conversion enable |
| sar_code | input | RES_BITS | Code returned by the analog SAR model |
| sar_sample | output | 1 | Sample strobe toward the SAR model |
| sar_step | output | 1 | Bit-decision strobe toward the SAR model |
| conv_done | output | 1 | One-bus-clock conversion complete pulse |
| conv_result | output | RES_BITS | Last captured conversion code |

## Verification
The bench uses the default parameters: a 10-bit result, 16 full ADC cycles per conversion and a two-stage oscillator synchronizer. It covers all eight divide codes and both clock sources. With the bus clock as source, the scoreboard predicts the exact done edge from the prescaler phase set by the last clock register write. That exposes both the partial seventeenth cycle and the 16-cycle continuous spacing. With the oscillator as source, the oscillator period is 2.6 bus periods and its edges never coincide with bus edges, so the bench accepts done within a window set by the synchronizer delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int PRE_W = 4;

    // Divide code to terminal phase count (ratio - 1); unused codes divide by 1.
    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
        logic [PRE_W-1:0] lim;
        case (code)
            3'd1:    lim = 4'd1;
            3'd2:    lim = 4'd3;
            3'd3:    lim = 4'd7;
            3'd4:    lim = 4'd15;
            default: lim = 4'd0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/adc_clk_src.sv
module adc_clk_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_src_osc,
    input  logic osc_clk,
    output logic src_tick
);
    typedef struct packed {
        logic                   sel;
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } src_t;

    src_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_wr) s_d.sel = cfg_src_osc;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], osc_clk};
        s_d.prev  = s_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src_tick = s_q.sel ? (s_q.chain[SYNC_STAGES-1] & ~s_q.prev) : 1'b1;

    // R3: a synchronized oscillator edge yields a single-cycle tick
    a_r3_osc_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sel && src_tick) |=> !(s_q.sel && src_tick));

endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_div,
    input  logic       src_tick,
    output logic       adc_tick
);
    typedef struct packed {
        logic [PRE_W-1:0] lim;
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (cfg_wr) begin
            p_d.lim = div_limit(cfg_div);
            p_d.cnt = '0;
        end else if (src_tick) begin
            p_d.cnt = (p_q.cnt >= p_q.lim) ? '0 : PRE_W'(p_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign adc_tick = src_tick && !cfg_wr && (p_q.cnt >= p_q.lim);

    // R10: phase never leaves the programmed ratio
    a_r10_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= p_q.lim);
    // R10: a clock register write restarts the phase
    a_r10_write_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (p_q.cnt == '0));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
    parameter int RES_BITS   = 10,
    parameter int CONV_TICKS = 16,
    parameter int CHAN_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CHAN_W-1:0]   ctl_chan,
    input  logic                ctl_cont,
    input  logic                adc_tick,
    input  logic [RES_BITS-1:0] sar_code,
    output logic                sar_sample,
    output logic                sar_step,
    output logic                conv_done,
    output logic [RES_BITS-1:0] conv_result
);
    localparam int              CNT_W     = $clog2(CONV_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CONV_TICKS);
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(RES_BITS);

    typedef struct packed {
        logic                run;
        logic                cont;
        logic [CNT_W-1:0]    cnt;
        logic                sample;
        logic                step;
        logic                done;
        logic [RES_BITS-1:0] result;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        c_d.sample = 1'b0;
        c_d.step   = 1'b0;
        c_d.done   = 1'b0;
        if (ctl_wr) begin
            c_d.cont = ctl_cont;
            c_d.run  = (ctl_chan != '1);
            c_d.cnt  = '0;
        end else if (c_q.run && adc_tick) begin
            if (c_q.cnt == '0) begin
                c_d.sample = 1'b1;
                c_d.cnt    = CNT_W'(1);
            end else if (c_q.cnt < LAST_CNT) begin
                c_d.step = (c_q.cnt <= STEP_LAST);
                c_d.cnt  = CNT_W'(c_q.cnt + 1'b1);
            end else begin
                c_d.done   = 1'b1;
                c_d.result = sar_code;
                if (c_q.cont) begin
                    c_d.sample = 1'b1;
                    c_d.cnt    = CNT_W'(1);
                end else begin
                    c_d.run = 1'b0;
                    c_d.cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sar_sample  = c_q.sample;
    assign sar_step    = c_q.step;
    assign conv_done   = c_q.done;
    assign conv_result = c_q.result;

    a_r5_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);
    a_r6_sample_step_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sar_sample && sar_step));
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= LAST_CNT);
    a_r9_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.run |-> (!sar_sample && !sar_step));
    a_r8_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (c_q.cnt == '0 && !conv_done));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int RES_BITS    = 10,
    parameter int CONV_TICKS  = 16,
    parameter int CHAN_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_bus,
    input  logic                rst_n,
    input  logic                osc_clk,
    input  logic                cfg_wr,
    input  logic                cfg_src_osc,
    input  logic [2:0]          cfg_div,
    input  logic                ctl_wr,
    input  logic [CHAN_W-1:0]   ctl_chan,
    input  logic                ctl_cont,
    input  logic [RES_BITS-1:0] sar_code,
    output logic                sar_sample,
    output logic                sar_step,
    output logic                conv_done,
    output logic [RES_BITS-1:0] conv_result
);
    logic src_tick;
    logic adc_tick;

    adc_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk         (clk_bus),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_src_osc (cfg_src_osc),
        .osc_clk     (osc_clk),
        .src_tick    (src_tick)
    );

    adc_prescaler u_pre (
        .clk      (clk_bus),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_div  (cfg_div),
        .src_tick (src_tick),
        .adc_tick (adc_tick)
    );

    adc_conv_ctrl #(
        .RES_BITS   (RES_BITS),
        .CONV_TICKS (CONV_TICKS),
        .CHAN_W     (CHAN_W)
    ) u_ctl (
        .clk         (clk_bus),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_chan    (ctl_chan),
        .ctl_cont    (ctl_cont),
        .adc_tick    (adc_tick),
        .sar_code    (sar_code),
        .sar_sample  (sar_sample),
        .sar_step    (sar_step),
        .conv_done   (conv_done),
        .conv_result (conv_result)
    );

endmodule

// File: tb/adc_conv_seq_tb.sv
`timescale 1ns/1ps
module adc_conv_seq_tb;
    localparam real CLK_PERIOD = 10.0;
    localparam real OSC_HALF   = 13.0;
    localparam int  RES        = 10;
    localparam int  FULL       = 16;

    logic clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_src_osc = 0, ctl_wr = 0, ctl_cont = 0;
    logic [2:0] cfg_div = 0;
    logic [4:0] ctl_chan = 0;
    logic [RES-1:0] preset = 0, stub_q = 0;
    logic sar_sample, sar_step, conv_done;
    logic [RES-1:0] conv_result;

    int checks = 0, errors = 0, edge_n = 0;
    int w_edge = 0, cur_n = 1, steps = 0, done_total = 0, samp_total = 0;
    bit prev_done = 0, finished = 0;

    typedef struct { int lo; int hi; logic [RES-1:0] code; string tag; } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin #0.5; forever #(OSC_HALF) osc = ~osc; end
    always @(posedge clk) edge_n <= edge_n + 1;
    // Behavioural SAR stub: holds the preset code from each sample strobe
    always @(posedge clk) if (sar_sample) stub_q <= preset;

    adc_conv_seq u_dut (
        .clk_bus(clk), .rst_n(rst_n), .osc_clk(osc),
        .cfg_wr(cfg_wr), .cfg_src_osc(cfg_src_osc), .cfg_div(cfg_div),
        .ctl_wr(ctl_wr), .ctl_chan(ctl_chan), .ctl_cont(ctl_cont),
        .sar_code(stub_q), .sar_sample(sar_sample), .sar_step(sar_step),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'd1: return 2; 3'd2: return 4; 3'd3: return 8; 3'd4: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic cfg(input bit osc_sel, input logic [2:0] code);
        @(negedge clk);
        cfg_wr = 1; cfg_src_osc = osc_sel; cfg_div = code;
        @(negedge clk);
        cfg_wr = 0; w_edge = edge_n; cur_n = ratio(code);
    endtask

    task automatic start(input logic [4:0] ch, input bit cont, output int e);
        @(negedge clk);
        ctl_wr = 1; ctl_chan = ch; ctl_cont = cont;
        @(negedge clk);
        ctl_wr = 0; e = edge_n;
    endtask

    // Expected done edge for bus source (R2, R10): first tick after e, then FULL ratios
    function automatic int exact_done(input int e);
        int first;
        first = w_edge + cur_n * ((e - w_edge) / cur_n + 1);
        return first + FULL * cur_n;
    endfunction

    task automatic push(input int lo, input int hi, input logic [RES-1:0] c, input string t);
        exp_t x;
        x.lo = lo; x.hi = hi; x.code = c; x.tag = t;
        sb.push_back(x);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) if (rst_n) begin
        chk(!(prev_done && conv_done), "R5 done width", 2, 1);
        prev_done = conv_done;
        if (conv_done) begin
            done_total++;
            if (sb.size() == 0) chk(0, "R8/R9 unexpected done", edge_n, -1);
            else begin
                exp_t x;
                x = sb.pop_front();
                chk(edge_n >= x.lo && edge_n <= x.hi, x.tag, edge_n, x.lo);
                chk(conv_result == x.code, "R5 result", conv_result, x.code);
                chk(steps == RES, "R6 step count", steps, RES);
            end
        end
        if (sar_sample) begin steps = 0; samp_total++; end
        if (sar_step) steps++;
    end

    task automatic single_bus(input logic [2:0] code, input int gap, input logic [RES-1:0] c);
        int e;
        cfg(0, code);
        repeat (gap) @(negedge clk);
        preset = c;
        start(5'd3, 0, e);
        push(exact_done(e), exact_done(e), c, "R2/R4/R10 exact done edge");
        drain();
    endtask

    initial begin
        int e, d0, dn, sn;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(conv_done == 0, "R1 done", conv_done, 0);
        chk(sar_sample == 0, "R1 sample", sar_sample, 0);
        chk(sar_step == 0, "R1 step", sar_step, 0);
        chk(conv_result == 0, "R1 result", conv_result, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R4 R10: every divide code, bus source, varied phase
        single_bus(3'd0, 0, 10'h2A5);
        single_bus(3'd1, 1, 10'h155);
        single_bus(3'd2, 2, 10'h3FF);
        single_bus(3'd3, 5, 10'h001);
        single_bus(3'd4, 9, 10'h200);
        single_bus(3'd5, 3, 10'h0F0);
        single_bus(3'd6, 0, 10'h10F);
        single_bus(3'd7, 2, 10'h333);

        // R8: abort a running conversion by a new write
        cfg(0, 3'd2);
        preset = 10'h0AA;
        start(5'd1, 0, e);
        repeat (30) @(negedge clk);
        preset = 10'h155;
        start(5'd2, 0, e);
        push(exact_done(e), exact_done(e), 10'h155, "R8 restart done edge");
        drain();

        // R9: power-down write cancels and starts nothing
        cfg(0, 3'd1);
        start(5'd4, 0, e);
        repeat (10) @(negedge clk);
        start(5'h1F, 0, e);
        dn = done_total; sn = samp_total;
        repeat (80) @(negedge clk);
        chk(done_total == dn, "R9 no done", done_total, dn);
        chk(samp_total == sn, "R9 no sample", samp_total, sn);
        start(5'h1F, 1, e);
        repeat (80) @(negedge clk);
        chk(done_total == dn, "R9 no done with cont", done_total, dn);

        // R7: continuous mode, spacing FULL ratios, then stop
        cfg(0, 3'd1);
        preset = 10'h1C3;
        start(5'd0, 1, e);
        d0 = exact_done(e);
        for (int k = 0; k < 4; k++)
            push(d0 + k*FULL*cur_n, d0 + k*FULL*cur_n, 10'h1C3, "R7 continuous spacing");
        while (sb.size() != 0) @(negedge clk);
        start(5'h1F, 0, e);
        dn = done_total;
        repeat (100) @(negedge clk);
        chk(done_total == dn, "R7 stops after write", done_total, dn);

        // R3: oscillator source through synchronizer, window check
        for (int code = 0; code < 3; code++) begin
            int n;
            cfg(1, 3'(code));
            n = ratio(3'(code));
            repeat (code + 1) @(negedge clk);
            preset = 10'(10'h050 + code);
            start(5'd6, 0, e);
            push(e + (FULL*n*26)/10 - 3, e + ((FULL+1)*n*26)/10 + 5,
                 10'(10'h050 + code), "R3 osc done window");
            drain();
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule